// File: doc/BRIEF.md
# March-Sequence Memory Self-Test Controller

This block is a built-in self-test engine for one synchronous single-port RAM. When the system pulses `start`, it drives the RAM through a fixed march algorithm and then raises `done`. If any read returned the wrong word, `fail` is also high and a set of diagnostic registers holds the details. The engine issues one memory operation per clock. The total run time is twelve operations per word plus one drain cycle, so it grows linearly with depth.

The algorithm has four phases, called elements:

- Element 0 writes zeros to every word in ascending order.
- Element 1 also runs upward. At each word it reads expecting zeros, writes ones, reads ones, writes ones again and reads ones.
- Element 2 runs downward. At each word it reads ones, writes zeros, reads zeros, writes zeros and reads zeros.
- Element 3 reads every word once more, in ascending order, expecting zeros.

The engine finishes all the operations of an element on one word before it moves to the next word. Each element expects the value the previous element left behind. A cell that cannot rise is therefore caught by the read-back in element 1, and a cell that cannot fall is caught in element 2. Each data bit is copied across the full word, so every written or expected word is all zeros or all ones.

The RAM returns read data one clock after the read, so the comparison runs one stage behind the issued operation. The first mismatch is captured: the word address, the element index, the operation index within that element, and the expected word. The run still continues to its end.

Top module: `mbist_march`

## Requirements
- R1: While `rst_n` is low at a clock edge, the engine goes idle. `busy`, `done`, `fail` and `mem_en` are then 0.
- R2: When `start` is high at an edge while the engine is idle, a run begins, and `busy` is 1 from that edge. A `start` pulse during a run has no effect on the memory operation sequence or on its timing.
- R3: Operation k of a run (k = 0 is the cycle after the accepting edge) has `mem_en`=1 and follows this list. With N words and k < N, it writes zeros at address k. Element 1 follows, then element 2, with j the offset into the element, op = j mod 5 and word = j div 5. Element 1 (N ≤ k < 6N, j = k−N) issues, per word, read, write, read, write, read, with write data or expected value 0,1,1,1,1. Element 2 (6N ≤ k < 11N, j = k−6N) uses the same read/write pattern with values 1,0,0,0,0. Element 3 (11N ≤ k < 12N) is a read at address k−11N.
- R4: Elements 0, 1 and 3 visit addresses upward from 0. Element 2 visits them downward, so its address is N−1−word.
- R5: Every written word (`mem_we`=1) is all zeros or all ones. It is never a mix.
- R6: After 12·N operation cycles there is one cycle with `busy`=1 and `mem_en`=0. On the next cycle `done` is 1 and `busy` is 0. `done` then stays 1 until the next accepted start.
- R7: Read data is compared against the replicated expected value one cycle after the read. On a fault-free RAM, `fail` is 0 when `done` rises.
- R8: At the first mismatch, `fail` is set and stays set. `fail_addr`, `fail_elem` (0–3), `fail_op` (0–4) and `fail_exp` capture the failing read and are not changed by later mismatches. The run still completes with the timing of R6.
- R9: An accepted start clears `done` and `fail` from that edge on.
- R10: A low `rst_n` in the middle of a run ends it. `busy`, `fail` and `mem_en` go to 0 and `done` stays 0.
- R11: A bit that cannot rise, or is stuck at 0, is reported at element 1, op 2, with `fail_exp` all ones. A bit stuck at 1 is reported at element 1, op 0, with `fail_exp` all zeros. A bit that cannot fall is reported at element 2, op 2, with `fail_exp` all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a test run (only honoured when idle) |
| busy | output | 1 | A run is in progress |
| done | output | 1 | Last run has finished; held until next start |
| fail | output | 1 | Sticky: at least one read mismatched |
| fail_addr | output | AW | Word address of the first mismatch |
| fail_elem | output | 2 | Element index of the first mismatch |
| fail_op | output | 3 | Operation index within the element of the first mismatch |
| fail_exp | output | DATA_W | Expected word of the first mismatching read |
| mem_en | output | 1 | Memory access enable for this cycle |
| mem_we | output | 1 | Write when 1, read when 0 |
| mem_addr | output | AW | Memory word address |
| mem_wdata | output | DATA_W | Memory write data |
| mem_rdata | input | DATA_W | Memory read data, valid one cycle after a read |

## Verification
A wrong element, operation or address counter shows up at the memory port on the very cycle it goes astray. The bench compares every issued operation against the expected schedule, so the first bad operation is caught where it occurs. A broken element-end or direction decision also moves `done` away from cycle 12·N+1. Wrong detection logic shows up as a missing or mislocated failure report once `done` rises. That report is checked for each injected fault type against the element and operation where the fault must first show.

// File: rtl/mbist_pkg.sv
// Package: shared types and the fixed march schedule.
// Assumes four elements of at most five operations each.
package mbist_pkg;

    typedef logic [1:0] elem_t;
    typedef logic [2:0] opidx_t;

    // One march operation: write (1) or read (0), and the data bit
    // that is written or expected.
    typedef struct packed {
        logic wr;
        logic val;
    } step_t;

    localparam elem_t LAST_ELEM = 2'd3;

    // Operation kind and data bit for element e, operation o.
    function automatic step_t step_of(input elem_t e, input opidx_t o);
        step_t s;
        case (e)
            2'd0:    begin s.wr = 1'b1; s.val = 1'b0;        end
            2'd1:    begin s.wr = o[0]; s.val = (o != 3'd0); end
            2'd2:    begin s.wr = o[0]; s.val = (o == 3'd0); end
            default: begin s.wr = 1'b0; s.val = 1'b0;        end
        endcase
        return s;
    endfunction

    // Index of the final operation in element e.
    function automatic opidx_t last_op(input elem_t e);
        return (e == 2'd1 || e == 2'd2) ? 3'd4 : 3'd0;
    endfunction

    // Address direction of element e: 1 means descending.
    function automatic logic descending(input elem_t e);
        return (e == 2'd2);
    endfunction

endpackage

// File: rtl/mbist_seq.sv
// Module: march sequencer. Walks element, address and operation
// counters, one operation per clock, then spends one drain cycle.
// Assumes DEPTH >= 2 and a start that may arrive at any time.
module mbist_seq
    import mbist_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int AW    = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    output logic          accept,
    output logic          busy,
    output logic          issue,
    output logic          flush,
    output elem_t         elem,
    output opidx_t        op,
    output logic [AW-1:0] addr
);

    typedef enum logic [1:0] {S_IDLE, S_RUN, S_FLUSH} state_t;

    localparam logic [AW-1:0] TOP_ADDR = AW'(DEPTH - 1);

    state_t        state;
    logic          elem_end_op;
    logic          addr_at_end;
    logic [AW-1:0] end_addr;
    logic [AW-1:0] next_addr;
    elem_t         next_elem;

    // Decode the end-of-element conditions and the next address.
    always_comb begin
        next_elem   = elem + 2'd1;
        end_addr    = descending(elem) ? '0 : TOP_ADDR;
        elem_end_op = (op == last_op(elem));
        addr_at_end = (addr == end_addr);
        next_addr   = descending(elem) ? addr - AW'(1) : addr + AW'(1);
    end

    assign accept = (state == S_IDLE) && start;
    assign busy   = (state != S_IDLE);
    assign issue  = (state == S_RUN);
    assign flush  = (state == S_FLUSH);

    // Advance the state, element, address and operation counters.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= S_IDLE;
            elem  <= '0;
            op    <= '0;
            addr  <= '0;
        end else begin
            case (state)
                S_IDLE: begin
                    if (start) begin
                        state <= S_RUN;
                        elem  <= '0;
                        op    <= '0;
                        addr  <= '0;
                    end
                end
                S_RUN: begin
                    if (!elem_end_op) begin
                        op <= op + 3'd1;
                    end else begin
                        op <= '0;
                        if (!addr_at_end) begin
                            addr <= next_addr;
                        end else if (elem == LAST_ELEM) begin
                            state <= S_FLUSH;
                        end else begin
                            elem <= next_elem;
                            addr <= descending(next_elem) ? TOP_ADDR : '0;
                        end
                    end
                end
                default: state <= S_IDLE;
            endcase
        end
    end

    AST_ADDR_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        issue |-> addr <= TOP_ADDR) else $error("address out of range"); // R4

    AST_STEP_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
        issue && !elem_end_op |=> issue && elem == $past(elem) && addr == $past(addr)
            && op == opidx_t'($past(op) + 3'd1)) else $error("op did not advance"); // R3

    AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        busy && start |=> !(issue && elem == 2'd0 && addr == '0))
        else $error("restart during run"); // R2

endmodule

// File: rtl/mbist_check.sv
// Module: response checker. Registers each issued read for one cycle,
// compares the returned word with the replicated expected bit, keeps
// a sticky fail flag and the first failure's diagnostics, and raises
// done after the drain cycle. Assumes read latency of exactly one.
module mbist_check
    import mbist_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int AW     = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              issue,
    input  step_t             step,
    input  logic [AW-1:0]     addr,
    input  elem_t             elem,
    input  opidx_t            op,
    input  logic              flush,
    input  logic [DATA_W-1:0] rdata,
    output logic              fail,
    output logic              done,
    output logic [AW-1:0]     fail_addr,
    output elem_t             fail_elem,
    output opidx_t            fail_op,
    output logic [DATA_W-1:0] fail_exp
);

    logic          pend_rd;
    logic          pend_val;
    logic [AW-1:0] pend_addr;
    elem_t         pend_elem;
    opidx_t        pend_op;
    logic          mismatch;

    // Hold the attributes of the read issued in the previous cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_rd   <= 1'b0;
            pend_val  <= 1'b0;
            pend_addr <= '0;
            pend_elem <= '0;
            pend_op   <= '0;
        end else begin
            pend_rd   <= issue && !step.wr;
            pend_val  <= step.val;
            pend_addr <= addr;
            pend_elem <= elem;
            pend_op   <= op;
        end
    end

    // Compare the returned word with the expected background.
    assign mismatch = pend_rd && (rdata != {DATA_W{pend_val}});

    // Keep the sticky result, the first-failure record and done.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            fail      <= 1'b0;
            done      <= 1'b0;
            fail_addr <= '0;
            fail_elem <= '0;
            fail_op   <= '0;
            fail_exp  <= '0;
        end else begin
            if (mismatch && !fail) begin
                fail      <= 1'b1;
                fail_addr <= pend_addr;
                fail_elem <= pend_elem;
                fail_op   <= pend_op;
                fail_exp  <= {DATA_W{pend_val}};
            end
            if (flush) begin
                done <= 1'b1;
            end
        end
    end

    AST_FAIL_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        fail && !clear |=> fail) else $error("fail dropped"); // R8

    AST_CAPTURE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        fail && !clear |=> $stable(fail_addr) && $stable(fail_elem)
            && $stable(fail_op) && $stable(fail_exp)) else $error("capture overwritten"); // R8

    AST_FIRST_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
        mismatch && !fail && !clear |=> fail && fail_addr == $past(pend_addr))
        else $error("first mismatch not captured"); // R7

    AST_DONE_AFTER_DRAIN: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> done) else $error("done missing after drain"); // R6

endmodule

// File: rtl/mbist_march.sv
// Module: top of the march self-test controller. Joins the sequencer
// and the checker and forms the memory port. Assumes a single-port
// synchronous RAM that returns read data one clock after the read.
module mbist_march
    import mbist_pkg::*;
#(
    parameter int  DEPTH  = 16,
    parameter int  DATA_W = 8,
    localparam int AW     = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    output logic              busy,
    output logic              done,
    output logic              fail,
    output logic [AW-1:0]     fail_addr,
    output logic [1:0]        fail_elem,
    output logic [2:0]        fail_op,
    output logic [DATA_W-1:0] fail_exp,
    output logic              mem_en,
    output logic              mem_we,
    output logic [AW-1:0]     mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata
);

    logic          accept;
    logic          issue;
    logic          flush;
    elem_t         elem;
    opidx_t        op;
    logic [AW-1:0] addr;
    step_t         step;

    mbist_seq #(.DEPTH(DEPTH), .AW(AW)) u_seq (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (start),
        .accept (accept),
        .busy   (busy),
        .issue  (issue),
        .flush  (flush),
        .elem   (elem),
        .op     (op),
        .addr   (addr)
    );

    // Look up the current operation and drive the memory port.
    always_comb begin
        step      = step_of(elem, op);
        mem_en    = issue;
        mem_we    = issue && step.wr;
        mem_addr  = addr;
        mem_wdata = {DATA_W{step.val}};
    end

    mbist_check #(.DATA_W(DATA_W), .AW(AW)) u_check (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (accept),
        .issue     (issue),
        .step      (step),
        .addr      (addr),
        .elem      (elem),
        .op        (op),
        .flush     (flush),
        .rdata     (mem_rdata),
        .fail      (fail),
        .done      (done),
        .fail_addr (fail_addr),
        .fail_elem (fail_elem),
        .fail_op   (fail_op),
        .fail_exp  (fail_exp)
    );

    AST_WDATA_SOLID: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> (mem_wdata == '0 || mem_wdata == '1)) else $error("mixed write data"); // R5

    AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy) else $error("done while busy"); // R6

endmodule

// File: tb/tb_mbist_march.sv
`timescale 1ns/1ps
module tb_mbist_march;

    localparam int N   = 16;
    localparam int W   = 8;
    localparam int AW  = 4;
    localparam int OPS = 12 * N;
    localparam logic [4:0] E1_WR  = 5'b01010;
    localparam logic [4:0] E1_VAL = 5'b11110;
    localparam logic [4:0] E2_WR  = 5'b01010;
    localparam logic [4:0] E2_VAL = 5'b00001;

    // fault kinds
    localparam int F_NONE = 0, F_SA0 = 1, F_SA1 = 2, F_UTF = 3, F_DTF = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic          busy, done, fail, mem_en, mem_we;
    logic [AW-1:0] fail_addr, mem_addr;
    logic [1:0]    fail_elem;
    logic [2:0]    fail_op;
    logic [W-1:0]  fail_exp, mem_wdata;
    logic [W-1:0]  mem_rdata = '0;

    logic [W-1:0] ram [N];
    logic [W-1:0] sa0 [N];
    logic [W-1:0] sa1 [N];
    logic [W-1:0] utf [N];
    logic [W-1:0] dtf [N];
    logic         wipe = 1'b0;

    int checks = 0;
    int failures = 0;

    always #5 clk = ~clk;

    mbist_march #(.DEPTH(N), .DATA_W(W)) dut (
        .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
        .fail(fail), .fail_addr(fail_addr), .fail_elem(fail_elem),
        .fail_op(fail_op), .fail_exp(fail_exp), .mem_en(mem_en),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata)
    );

    function automatic logic [W-1:0] apply_write(input logic [W-1:0] old_w,
            input logic [W-1:0] new_w, input logic [W-1:0] up_m, input logic [W-1:0] dn_m);
        logic [W-1:0] r;
        r = (new_w & ~up_m) | (new_w & old_w & up_m);
        r = (r & ~dn_m) | ((r | old_w) & dn_m);
        return r;
    endfunction

    // RAM model with injectable faults, one-cycle read latency.
    always @(posedge clk) begin
        if (wipe) begin
            for (int i = 0; i < N; i++) ram[i] <= '0;
        end else if (mem_en) begin
            if (mem_we)
                ram[mem_addr] <= apply_write(ram[mem_addr], mem_wdata, utf[mem_addr], dtf[mem_addr]);
            else
                mem_rdata <= (ram[mem_addr] | sa1[mem_addr]) & ~sa0[mem_addr];
        end
    end

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Expected memory operation k of a run (R3, R4, R5).
    function automatic void exp_step(input int k, output bit we, output int a, output bit v);
        int j;
        if (k < N) begin
            we = 1'b1; a = k; v = 1'b0;
        end else if (k < 6 * N) begin
            j = k - N; a = j / 5; we = E1_WR[j % 5]; v = E1_VAL[j % 5];
        end else if (k < 11 * N) begin
            j = k - 6 * N; a = N - 1 - j / 5; we = E2_WR[j % 5]; v = E2_VAL[j % 5];
        end else begin
            we = 1'b0; a = k - 11 * N; v = 1'b0;
        end
    endfunction

    // Expected first-failure report for a single fault kind (R11).
    function automatic void exp_fault(input int kind, output int el, output int o,
                                      output logic [W-1:0] ex);
        case (kind)
            F_SA1:   begin el = 1; o = 0; ex = '0; end
            F_DTF:   begin el = 2; o = 2; ex = '0; end
            default: begin el = 1; o = 2; ex = '1; end
        endcase
    endfunction

    task automatic clear_faults();
        for (int i = 0; i < N; i++) begin
            sa0[i] = '0; sa1[i] = '0; utf[i] = '0; dtf[i] = '0;
        end
        @(negedge clk); wipe = 1'b1;
        @(negedge clk); wipe = 1'b0;
    endtask

    task automatic inject(input int kind, input int a, input int b);
        case (kind)
            F_SA0: sa0[a][b] = 1'b1;
            F_SA1: sa1[a][b] = 1'b1;
            F_UTF: utf[a][b] = 1'b1;
            F_DTF: dtf[a][b] = 1'b1;
            default: ;
        endcase
    endtask

    // One complete run; checks schedule, timing and clearing.
    task automatic run_march(input bit poke);
        int k;
        int terr;
        bit cleared;
        bit we_e, v_e;
        int a_e;
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        k = 0; terr = 0;
        cleared = !fail && !done && busy;
        while (!done && k < OPS + 8) begin
            if (k < OPS) begin
                exp_step(k, we_e, a_e, v_e);
                if (!mem_en || mem_we != we_e || int'(mem_addr) != a_e
                    || (we_e && mem_wdata != {W{v_e}})) terr++;
            end else if (mem_en) begin
                terr++;
            end
            if (!busy) terr++;
            if (poke && k == 7) start = 1'b1;
            if (poke && k == 8) start = 1'b0;
            @(negedge clk);
            k++;
        end
        check(cleared, "R9", "fail/done cleared at start", fail, 0);
        check(terr == 0, "R3", "operation schedule errors", terr, 0);
        check(k == OPS + 1, "R6", "cycles from start to done", k, OPS + 1);
        check(!busy, "R6", "busy after done", busy, 0);
        @(negedge clk);
        check(done, "R6", "done held", done, 1);
    endtask

    task automatic expect_report(input string req, input int a, input int el,
                                 input int o, input logic [W-1:0] ex);
        check(fail, req, "fail flag", fail, 1);
        check(int'(fail_addr) == a, req, "fail_addr", fail_addr, a);
        check(int'(fail_elem) == el, req, "fail_elem", fail_elem, el);
        check(int'(fail_op) == o, req, "fail_op", fail_op, o);
        check(fail_exp == ex, req, "fail_exp", fail_exp, ex);
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        #(200000 * 10);
        failures++;
        $display("FAIL R6 watchdog expired actual=%0d expected=%0d", 1, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        int kind, a, b, el, o, a2;
        logic [W-1:0] ex;
        void'($urandom(32'd4242));
        for (int i = 0; i < N; i++) begin
            sa0[i] = '0; sa1[i] = '0; utf[i] = '0; dtf[i] = '0;
        end
        repeat (3) @(negedge clk);
        // R1: reset state
        check(!busy && !done && !fail && !mem_en, "R1", "outputs in reset",
              {busy, done, fail, mem_en}, 0);
        rst_n = 1'b1;
        clear_faults();
        @(negedge clk);
        check(!busy && !done, "R1", "idle after reset", {busy, done}, 0);

        // Fault-free run with a start pulse during the run (R2, R3, R4, R5, R6, R7)
        run_march(1'b1);
        check(!fail, "R7", "fault-free run", fail, 0);
        check(!busy, "R2", "no restart from busy start", busy, 0);

        // Stuck-at-1 at lowest address (R11, R8)
        clear_faults(); inject(F_SA1, 0, 0);
        run_march(1'b0);
        expect_report("R11", 0, 1, 0, '0);

        // Cannot-fall at top address (R11)
        clear_faults(); inject(F_DTF, N - 1, W - 1);
        run_march(1'b0);
        expect_report("R11", N - 1, 2, 2, '0);

        // R9: fault-free run after a failing one clears fail
        clear_faults();
        run_march(1'b0);
        check(!fail, "R9", "fail cleared by new run", fail, 0);

        // R8: two stuck-at-1 cells, first in ascending order wins
        clear_faults(); inject(F_SA1, 3, 1); inject(F_SA1, 11, 6);
        run_march(1'b0);
        expect_report("R8", 3, 1, 0, '0);

        // R4: two cannot-fall cells, descending element finds the upper one
        clear_faults(); inject(F_DTF, 4, 2); inject(F_DTF, 12, 5);
        run_march(1'b0);
        expect_report("R4", 12, 2, 2, '0);

        // R11: random single faults
        for (int t = 0; t < 10; t++) begin
            kind = int'($urandom_range(F_SA0, F_DTF));
            a = int'($urandom_range(0, N - 1));
            b = int'($urandom_range(0, W - 1));
            clear_faults(); inject(kind, a, b);
            run_march(t[0]);
            exp_fault(kind, el, o, ex);
            expect_report("R11", a, el, o, ex);
        end

        // R8: random stuck-at-0 plus cannot-rise in element 1, lower address first
        a = int'($urandom_range(0, N / 2 - 1));
        a2 = int'($urandom_range(N / 2, N - 1));
        clear_faults(); inject(F_UTF, a2, 0); inject(F_SA0, a, 7);
        run_march(1'b0);
        expect_report("R8", a, 1, 2, '1);

        // R10: reset during a run that has already failed
        clear_faults(); inject(F_SA1, 0, 3);
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        repeat (N + 6) @(negedge clk);
        check(fail && busy, "R10", "failed mid-run before reset", {fail, busy}, 3);
        rst_n = 1'b0;
        @(negedge clk);
        check(!busy && !fail && !done && !mem_en, "R10", "state after mid-run reset",
              {busy, fail, done, mem_en}, 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        check(!busy && !mem_en, "R10", "stays idle after reset", {busy, mem_en}, 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule